// File: doc/BRIEF.md
# Slope-Based Raw Waveform Suppressor

This block serves one group of eight digitizer channels and decides, once per event window, whether the raw waveform samples of each channel are worth keeping. A channel counts as hit when its signal moves by more than a programmable threshold between a sample and the sample taken three valid clocks earlier. Comparing against that older sample removes the baseline without a separate pedestal register. An optional pairing mode runs the same slope test on the sum of two neighbouring channels, so that signals shared across a pair can be found at a threshold about twice the single-channel value.

A window opens with a start strobe and closes with an end strobe. Slope hits are ORed together while the window is open. At the end strobe the block latches one hit flag and one keep flag per channel and holds them until the next end strobe. The readout logic uses the keep flags to drop waveform records. Three policies select them: keep every enabled channel, keep only enabled channels that were hit, or keep none. The hit flags are reported under all three policies. A per-channel enable mask removes idle inputs, and a polarity mode restricts detection to falling edges.

Top module: `slope_suppressor`

## Requirements
- R1: While `rst` is high, `keep_o` and `hit_o` are all zero after each clock edge.
- R2: With `mode_invert` low, a valid sample whose value differs from the valid sample three positions earlier in the same window by strictly more than `hit_thr` (absolute difference) marks that channel hit. A difference equal to the threshold does not.
- R3: With `mode_invert` high, only a fall strictly larger than `hit_thr` (older sample minus newer sample) marks a hit. A rise of any size does not.
- R4: The slope test uses only valid samples of the current window. The first three valid samples after `win_start` cannot produce a hit, and cycles with `smp_valid` low neither shift the history nor produce hits, whatever `smp_data` carries.
- R5: Hits are ORed over the window. `win_start` discards earlier hits. `hit_o` and `keep_o` change only on the clock edge where `win_end` is high and hold their values at all other times.
- R6: With `mode_pair_sum` high, channels 2k and 2k+1 form a pair. The slope test is applied to the sum of both samples, and a pair hit sets the hit flag of both enabled channels of that pair.
- R7: A channel whose bit in `chan_enable` is 0 always latches hit 0 and keep 0.
- R8: With `mode_drop_all` high, every keep flag latches 0, while hit flags are still latched normally.
- R9: With `mode_drop_all` low, `mode_drop_idle` high latches keep = hit per channel. With both low, keep = `chan_enable`.
- R10: A hit found on the sample presented in the same cycle as `win_end` is included in the latched result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| win_start | input | 1 | Opens an event window; clears accumulated hits and history count |
| win_end | input | 1 | Closes the window; latches hit and keep flags |
| smp_valid | input | 1 | Qualifies `smp_data` in this cycle |
| smp_data | input | NCH*SW (96) | Unsigned samples, channel c at bits [c*SW +: SW] |
| chan_enable | input | NCH (8) | Per-channel enable, bit c for channel c |
| hit_thr | input | SW+2 (14) | Slope threshold; nominal value 10 |
| mode_drop_all | input | 1 | Drop raw data of every channel |
| mode_drop_idle | input | 1 | Drop raw data of channels with no hit |
| mode_pair_sum | input | 1 | Slope test on the sum of neighbouring pairs |
| mode_invert | input | 1 | Falling-edge-only detection |
| keep_o | output | NCH (8) | Latched keep flag per channel |
| hit_o | output | NCH (8) | Latched hit flag per channel |

## Verification
The hardest case to reach from the ports is history that is stale or not qualified. A sample left over from the previous window, or one presented while `smp_valid` is low, would give a large false slope if the design used it. The stimulus first runs a window of zeros and then a flat window at a different level, which would show a hit at once if the history were not re-primed. A further window interleaves invalid cycles carrying full-scale garbage between the flat valid samples. Pairs with opposing and matching sub-threshold steps show that the sum, and not either channel alone, decides the hit.

// File: rtl/ssup_pkg.sv
package ssup_pkg;

    localparam int GRP_CH     = 8;
    localparam int SMP_W      = 12;
    localparam int SLOPE_SPAN = 3;

    typedef struct packed {
        logic drop_all;
        logic drop_idle;
        logic pair_sum;
        logic invert;
    } ssup_mode_t;

    typedef enum logic [1:0] {
        KEEP_ALL    = 2'd0,
        KEEP_NONE   = 2'd1,
        KEEP_ON_HIT = 2'd2
    } keep_pol_e;

    // drop-all overrides the per-channel policy
    function automatic keep_pol_e keep_policy(input ssup_mode_t m);
        if (m.drop_all)
            return KEEP_NONE;
        else if (m.drop_idle)
            return KEEP_ON_HIT;
        else
            return KEEP_ALL;
    endfunction

endpackage

// File: rtl/ssup_slope_tap.sv
module ssup_slope_tap #(
    parameter int NCH  = 8,
    parameter int SW   = 12,
    parameter int SPAN = 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  win_start,
    input  logic                  smp_valid,
    input  logic [NCH*SW-1:0]     smp_data,
    output logic [NCH*(SW+1)-1:0] diff_o,
    output logic                  primed_o
);
    localparam int CW = $clog2(SPAN + 1);
    localparam int DW = SW + 1;

    // count of valid samples seen in this window, saturating at SPAN
    logic [CW-1:0] fill_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            fill_cnt <= '0;
        else if (win_start)
            fill_cnt <= smp_valid ? CW'(1) : '0;
        else if (smp_valid && fill_cnt != CW'(SPAN))
            fill_cnt <= fill_cnt + 1'b1;
    end

    assign primed_o = (fill_cnt == CW'(SPAN)) && !win_start;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic [SW-1:0] tap [SPAN];
        logic [SW-1:0] cur;

        assign cur = smp_data[ch*SW +: SW];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < SPAN; i++) tap[i] <= '0;
            end else if (smp_valid) begin
                tap[0] <= cur;
                for (int i = 1; i < SPAN; i++) tap[i] <= tap[i-1];
            end
        end

        assign diff_o[ch*DW +: DW] = $signed({1'b0, cur}) - $signed({1'b0, tap[SPAN-1]});
    end

endmodule

// File: rtl/ssup_hit_eval.sv
module ssup_hit_eval #(
    parameter int NCH = 8,
    parameter int SW  = 12
) (
    input  logic [NCH*(SW+1)-1:0] diff_i,
    input  logic                  primed_i,
    input  logic                  smp_valid,
    input  logic                  pair_sum,
    input  logic                  invert,
    input  logic [SW+1:0]         thr,
    output logic [NCH-1:0]        hit_now
);
    localparam int DW    = SW + 1;
    localparam int MW    = SW + 3;
    localparam int NPAIR = NCH / 2;

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        logic [DW-1:0]        raw_a, raw_b;
        logic signed [MW-1:0] d_a, d_b, d_sum;

        assign raw_a = diff_i[(2*p)*DW   +: DW];
        assign raw_b = diff_i[(2*p+1)*DW +: DW];
        assign d_a   = {{2{raw_a[DW-1]}}, raw_a};
        assign d_b   = {{2{raw_b[DW-1]}}, raw_b};
        // slope of the sum equals the sum of the slopes
        assign d_sum = d_a + d_b;

        for (genvar j = 0; j < 2; j++) begin : g_side
            logic signed [MW-1:0] d_sel, mag;

            assign d_sel = pair_sum ? d_sum : ((j == 0) ? d_a : d_b);
            assign mag   = invert ? -d_sel : (d_sel[MW-1] ? -d_sel : d_sel);
            assign hit_now[2*p+j] = smp_valid && primed_i && !mag[MW-1]
                                    && (mag[MW-2:0] > thr);
        end
    end

endmodule

// File: rtl/ssup_window_latch.sv
module ssup_window_latch
    import ssup_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           win_start,
    input  logic           win_end,
    input  logic [NCH-1:0] hit_now,
    input  logic [NCH-1:0] chan_en,
    input  keep_pol_e      policy,
    input  logic           pair_sum,
    output logic [NCH-1:0] keep_o,
    output logic [NCH-1:0] hit_o
);
    logic [NCH-1:0] acc;
    logic [NCH-1:0] window_hits;

    assign window_hits = (win_start ? '0 : acc) | hit_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc    <= '0;
            hit_o  <= '0;
            keep_o <= '0;
        end else begin
            acc <= window_hits;
            if (win_end) begin
                hit_o <= window_hits & chan_en;
                case (policy)
                    KEEP_NONE:   keep_o <= '0;
                    KEEP_ON_HIT: keep_o <= window_hits & chan_en;
                    default:     keep_o <= chan_en;
                endcase
            end
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (keep_o == '0 && hit_o == '0));

    assert_hold_between_R5: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> ($stable(hit_o) && $stable(keep_o)));

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (((hit_o | keep_o) & ~$past(chan_en)) == '0));

    assert_drop_all_R8: assert property (@(posedge clk) disable iff (rst)
        (win_end && policy == KEEP_NONE) |=> (keep_o == '0));

    assert_keep_follows_hit_R9: assert property (@(posedge clk) disable iff (rst)
        (win_end && policy == KEEP_ON_HIT) |=> (keep_o == hit_o));

    for (genvar p = 0; p < NCH / 2; p++) begin : g_pair_chk
        assert_pair_equal_R6: assert property (@(posedge clk) disable iff (rst)
            (win_end && pair_sum && chan_en[2*p] && chan_en[2*p+1])
            |=> (hit_o[2*p] == hit_o[2*p+1]));
    end

endmodule

// File: rtl/slope_suppressor.sv
module slope_suppressor
    import ssup_pkg::*;
#(
    parameter int NCH  = GRP_CH,
    parameter int SW   = SMP_W,
    parameter int SPAN = SLOPE_SPAN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              win_start,
    input  logic              win_end,
    input  logic              smp_valid,
    input  logic [NCH*SW-1:0] smp_data,
    input  logic [NCH-1:0]    chan_enable,
    input  logic [SW+1:0]     hit_thr,
    input  logic              mode_drop_all,
    input  logic              mode_drop_idle,
    input  logic              mode_pair_sum,
    input  logic              mode_invert,
    output logic [NCH-1:0]    keep_o,
    output logic [NCH-1:0]    hit_o
);
    localparam int DW = SW + 1;

    ssup_mode_t           mode;
    logic [NCH*DW-1:0]    diff;
    logic                 primed;
    logic [NCH-1:0]       hit_now;

    assign mode = '{drop_all:  mode_drop_all,
                    drop_idle: mode_drop_idle,
                    pair_sum:  mode_pair_sum,
                    invert:    mode_invert};

    ssup_slope_tap #(.NCH(NCH), .SW(SW), .SPAN(SPAN)) u_tap (
        .clk       (clk),
        .rst       (rst),
        .win_start (win_start),
        .smp_valid (smp_valid),
        .smp_data  (smp_data),
        .diff_o    (diff),
        .primed_o  (primed)
    );

    ssup_hit_eval #(.NCH(NCH), .SW(SW)) u_eval (
        .diff_i    (diff),
        .primed_i  (primed),
        .smp_valid (smp_valid),
        .pair_sum  (mode.pair_sum),
        .invert    (mode.invert),
        .thr       (hit_thr),
        .hit_now   (hit_now)
    );

    ssup_window_latch #(.NCH(NCH)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .win_start (win_start),
        .win_end   (win_end),
        .hit_now   (hit_now),
        .chan_en   (chan_enable),
        .policy    (keep_policy(mode)),
        .pair_sum  (mode.pair_sum),
        .keep_o    (keep_o),
        .hit_o     (hit_o)
    );

endmodule

// File: tb/slope_suppressor_bench.sv
module slope_suppressor_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ws = 1'b0, we = 1'b0, sv = 1'b0;
    logic [95:0] sd = '0;
    logic [7:0]  en = 8'hFF;
    logic [13:0] thr = 14'd10;
    logic        m_all = 1'b0, m_idle = 1'b0, m_pair = 1'b0, m_inv = 1'b0;
    logic [7:0]  keep, hit;

    always #4 clk = ~clk;

    slope_suppressor u_slope_suppressor (
        .clk(clk), .rst(rst), .win_start(ws), .win_end(we), .smp_valid(sv),
        .smp_data(sd), .chan_enable(en), .hit_thr(thr),
        .mode_drop_all(m_all), .mode_drop_idle(m_idle),
        .mode_pair_sum(m_pair), .mode_invert(m_inv),
        .keep_o(keep), .hit_o(hit)
    );

    typedef struct {
        logic [7:0] k;
        logic [7:0] h;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   wave[8][40];
    int   total = 0, bad = 0;
    bit   summary_done = 0;
    logic [7:0] last_k, last_h;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_flat(input int ch, input int lvl);
        for (int t = 0; t < 40; t++) wave[ch][t] = lvl;
    endtask

    task automatic set_step(input int ch, input int a, input int b, input int at);
        for (int t = 0; t < 40; t++) wave[ch][t] = (t < at) ? a : b;
    endtask

    task automatic all_flat(input int lvl);
        for (int c = 0; c < 8; c++) set_flat(c, lvl);
    endtask

    // reference hits from the requirements, over valid samples of one window
    function automatic logic [7:0] ref_hits(input int len);
        logic [7:0] h = '0;
        for (int c = 0; c < 8; c++) begin
            int b = c - (c % 2);
            for (int t = 3; t < len; t++) begin
                int d, m;
                if (m_pair)
                    d = wave[b][t] + wave[b+1][t] - wave[b][t-3] - wave[b+1][t-3];
                else
                    d = wave[c][t] - wave[c][t-3];
                m = m_inv ? -d : ((d < 0) ? -d : d);
                if (m > int'(thr)) h[c] = 1'b1;
            end
        end
        return h & en;
    endfunction

    task automatic run_win(input string tag, input int len, input bit gap);
        exp_t e;
        e.h   = ref_hits(len);
        e.k   = m_all ? 8'h00 : (m_idle ? e.h : en);
        e.tag = tag;
        q.push_back(e);
        last_k = e.k;
        last_h = e.h;
        for (int t = 0; t < len; t++) begin
            @(negedge clk);
            sv = 1'b1;
            ws = (t == 0);
            we = (t == len - 1);
            for (int c = 0; c < 8; c++) sd[c*12 +: 12] = 12'(wave[c][t]);
            if (gap && t < len - 1) begin
                @(negedge clk);
                sv = 1'b0; ws = 1'b0; we = 1'b0;
                sd = '1;
            end
        end
        @(negedge clk);
        sv = 1'b0; ws = 1'b0; we = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // monitor: compare latched flags one cycle after each window end
    initial begin
        forever begin
            @(posedge clk);
            if (we && !rst) begin
                exp_t e;
                @(negedge clk);
                #1;
                if (q.size() == 0) begin
                    total++; bad++;
                    $display("FAIL R5 unexpected latch actual=%h expected=none", hit);
                end else begin
                    e = q.pop_front();
                    chk({e.tag, " keep"}, keep, e.k);
                    chk({e.tag, " hit"},  hit,  e.h);
                end
            end
        end
    end

    task automatic finish_run;
        if (!summary_done) begin
            summary_done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        all_flat(0);
        repeat (3) @(negedge clk);
        chk("R1 reset keep", keep, 8'h00);
        chk("R1 reset hit",  hit,  8'h00);
        rst = 1'b0;
        repeat (2) @(negedge clk);

        // R2: magnitude slope, threshold boundary
        set_step(0, 100, 111, 4);
        set_step(1, 100, 110, 4);
        set_step(2, 200, 189, 4);
        set_flat(3, 300);
        for (int t = 0; t < 40; t++) wave[4][t] = 50 + 3 * t;
        set_flat(5, 0);
        set_step(6, 0, 4095, 5);
        set_flat(7, 4095);
        m_idle = 1'b1;
        run_win("R2 R9 abs slope drop idle", 8, 0);
        m_idle = 1'b0;
        run_win("R2 R9 abs slope keep enabled", 8, 0);

        // R3: falling edges only
        m_inv = 1'b1; m_idle = 1'b1;
        run_win("R3 inverted polarity", 8, 0);
        m_inv = 1'b0;

        // R4: stale history from the previous window must not count
        all_flat(0);
        run_win("R4 zero window", 8, 0);
        set_flat(4, 50);
        run_win("R4 fresh window unprimed", 8, 0);

        // R4: invalid cycles carry garbage and must not shift
        all_flat(100);
        run_win("R4 gap flat", 8, 1);
        set_step(1, 100, 120, 5);
        run_win("R4 gap with step", 8, 1);

        // R5: flags hold across idle cycles with garbage samples
        sv = 1'b0; sd = '1;
        repeat (5) @(negedge clk);
        chk("R5 hold hit", hit, last_h);
        chk("R5 hold keep", keep, last_k);
        all_flat(100);
        run_win("R5 cleared at start", 8, 0);

        // R6: adjacent pair sum
        set_step(0, 100, 106, 4);
        set_step(1, 100, 106, 4);
        set_step(2, 100, 106, 4);
        set_step(3, 100, 94, 4);
        set_step(4, 100, 111, 4);
        set_flat(5, 100);
        set_step(6, 100, 125, 4);
        set_flat(7, 100);
        en = 8'h7F;
        m_pair = 1'b1;
        run_win("R6 R7 pair sum", 8, 0);
        m_pair = 1'b0;
        run_win("R6 single channel contrast", 8, 0);

        // R7: masked channels
        all_flat(100);
        set_step(0, 100, 150, 4);
        set_step(5, 100, 150, 4);
        en = 8'hF0; m_idle = 1'b0;
        run_win("R7 masked channels", 8, 0);

        // R8: drop all still reports hits
        all_flat(200);
        set_step(3, 200, 240, 4);
        en = 8'hFF; m_all = 1'b1;
        run_win("R8 drop all", 8, 0);
        m_all = 1'b0;

        // R10: step on the window-end sample only
        all_flat(0);
        set_step(2, 0, 100, 7);
        m_idle = 1'b1;
        run_win("R10 last sample hit", 8, 0);

        repeat (4) @(negedge clk);
        if (q.size() != 0) begin
            total++; bad++;
            $display("FAIL R5 pending results actual=%0d expected=0", q.size());
        end
        finish_run();
    end

endmodule